// File: doc/BRIEF.md
# Four-Phase Asynchronous Write Link

This block carries single-word writes from a master clock domain to a slave clock domain over a request/acknowledge pair. Neither side shares a clock with the other. On a `start` pulse the master captures an address and a data word and drives them onto the link. It raises request and waits for acknowledge to rise. It then drops request and waits for acknowledge to fall. At that point it reports completion with a single-cycle `done` pulse.

The slave watches request through a synchronizer. When request rises, the slave writes the word into a small register file and raises acknowledge. It keeps acknowledge high until it sees request low. All four edges are interlocked, so either side may run faster than the other. Each domain also conditions its own reset so that the reset asserts at once and releases on its own clock. A combinational read port on the slave side lets a user inspect the stored words.

Top module: `async_wr_link`

## Requirements
- R1: During reset and right after it, `busy`, `done`, `link_req` and `link_ack` are low, and every storage word reads 0.
- R2: The master captures `wr_addr`/`wr_data` on an accepted `start` and drives them on the link at least one master cycle before request rises. They hold steady while request is high, whatever the user inputs do.
- R3: Request rises only while acknowledge is low, and falls only after the master has seen acknowledge high.
- R4: The slave writes the link word to the addressed storage entry when it sees request high, then raises acknowledge. Acknowledge rises only while request is high.
- R5: Acknowledge falls only after the slave has seen request low.
- R6: Each transfer yields exactly one `done` pulse, one master cycle wide. The pulse comes after acknowledge has returned low. By then the storage holds the new word.
- R7: `start` is ignored while `busy` is high. A start raised mid-transfer writes nothing and produces no extra `done` pulse.
- R8: `rd_data` always shows the word stored at `rd_addr`. Words that are not targeted by a write keep their value.
- R9: Each side samples the other's handshake line through a synchronizer of `SYNC_STAGES` flops. Transfers complete correctly when the two clocks have unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master domain clock |
| m_rst_n | input | 1 | Master domain asynchronous active-low reset |
| s_clk | input | 1 | Slave domain clock |
| s_rst_n | input | 1 | Slave domain asynchronous active-low reset |
| start | input | 1 | Begin a write (accepted only when idle) |
| wr_addr | input | ADDR_W | Target word address |
| wr_data | input | DATA_W | Word to write |
| busy | output | 1 | Master has a transfer in flight |
| done | output | 1 | One-cycle pulse when a transfer has completed |
| rd_addr | input | ADDR_W | Slave read-back address |
| rd_data | output | DATA_W | Stored word at `rd_addr` |
| link_req | output | 1 | Request line as driven by the master |
| link_ack | output | 1 | Acknowledge line as driven by the slave |

## Verification
The bench builds the block with its defaults: a 4-bit address (16 words), 8-bit data and two synchronizer stages. The slave clock runs at a 7 ns period against the 4 ns master clock, so the edge alignment between the domains drifts across transfers. Sixteen storage words let random writes revisit addresses many times, which exposes stale or misdirected writes. A monitor on the link lines checks the order of every handshake edge. Directed cases cover a start raised during a transfer and user inputs that change right after a start is accepted.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SETUP = 2'd1,
    M_REQ   = 2'd2,
    M_DROP  = 2'd3
  } m_state_t;

  typedef enum logic {
    S_WAIT = 1'b0,
    S_HOLD = 1'b1
  } s_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain_q[LAST];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_s,
  output logic              busy,
  output logic              done,
  output logic              req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);
  m_state_t          state_q, state_d;
  logic              req_q, req_d;
  logic              done_q, done_d;
  logic              cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    done_d  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      M_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          state_d = M_SETUP;
        end
      end
      M_SETUP: begin
        req_d   = 1'b1;
        state_d = M_REQ;
      end
      M_REQ: begin
        if (ack_s) begin
          req_d   = 1'b0;
          state_d = M_DROP;
        end
      end
      M_DROP: begin
        if (!ack_s) begin
          done_d  = 1'b1;
          state_d = M_IDLE;
        end
      end
      default: state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= in_addr;
      data_q <= in_data;
    end
  end

  assign busy     = (state_q != M_IDLE);
  assign done     = done_q;
  assign req      = req_q;
  assign bus_addr = addr_q;
  assign bus_data = data_q;

  assert_bus_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && $past(req_q)) |-> ($stable(addr_q) && $stable(data_q)));

  assert_req_drop_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_s));

  assert_req_rise_ack_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(ack_s));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_ack_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!req_q && !$past(ack_s)));
endmodule

// File: rtl/hs_regfile.sv
module hs_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] word_q [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_word
      logic hit;
      assign hit = we && (waddr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   word_q[gi] <= '0;
        else if (hit) word_q[gi] <= wdata;
      end
    end
  endgenerate

  assign rdata = word_q[raddr];
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack
);
  s_state_t state_q, state_d;
  logic     ack_q, ack_d;
  logic     wr_en;

  always_comb begin
    state_d = state_q;
    ack_d   = ack_q;
    wr_en   = 1'b0;
    unique case (state_q)
      S_WAIT: begin
        if (req_s) begin
          wr_en   = 1'b1;
          ack_d   = 1'b1;
          state_d = S_HOLD;
        end
      end
      S_HOLD: begin
        if (!req_s) begin
          ack_d   = 1'b0;
          state_d = S_WAIT;
        end
      end
      default: state_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_WAIT;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  hs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (bus_addr),
    .wdata (bus_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign ack = ack_q;

  assert_ack_rise_on_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_s));

  assert_ack_fall_on_req_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> !$past(req_s));

  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/async_wr_link.sv
module async_wr_link #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              m_clk,
  input  logic              m_rst_n,
  input  logic              s_clk,
  input  logic              s_rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              link_req,
  output logic              link_ack
);
  logic              m_rst_sync_n, s_rst_sync_n;
  logic              req_w, ack_w, req_s, ack_s;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;

  hs_sync #(.STAGES(SYNC_STAGES)) u_m_rst (
    .clk(m_clk), .rst_n(m_rst_n), .d(1'b1), .q(m_rst_sync_n));
  hs_sync #(.STAGES(SYNC_STAGES)) u_s_rst (
    .clk(s_clk), .rst_n(s_rst_n), .d(1'b1), .q(s_rst_sync_n));

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_to_m (
    .clk(m_clk), .rst_n(m_rst_sync_n), .d(ack_w), .q(ack_s));
  hs_sync #(.STAGES(SYNC_STAGES)) u_req_to_s (
    .clk(s_clk), .rst_n(s_rst_sync_n), .d(req_w), .q(req_s));

  hs_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk      (m_clk),
    .rst_n    (m_rst_sync_n),
    .start    (start),
    .in_addr  (wr_addr),
    .in_data  (wr_data),
    .ack_s    (ack_s),
    .busy     (busy),
    .done     (done),
    .req      (req_w),
    .bus_addr (bus_addr),
    .bus_data (bus_data)
  );

  hs_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slave (
    .clk      (s_clk),
    .rst_n    (s_rst_sync_n),
    .req_s    (req_s),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ack      (ack_w)
  );

  assign link_req = req_w;
  assign link_ack = ack_w;
endmodule

// File: tb/tb_async_wr_link.sv
module tb_async_wr_link;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic m_clk = 1'b0, s_clk = 1'b0;
  logic m_rst_n = 1'b0, s_rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic busy, done, link_req, link_ack;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  bit mon_on = 1'b0;
  logic prev_req = 1'b0, prev_ack = 1'b0;

  always #2 m_clk = ~m_clk;
  always #3.5 s_clk = ~s_clk;

  async_wr_link #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut (
    .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
    .start(start), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data),
    .link_req(link_req), .link_ack(link_ack));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mix(input int i);
    return DW'((i * 37 + 11) ^ (i >> 1));
  endfunction

  always @(negedge m_clk) if (done) done_cnt++;

  always @(posedge m_clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Handshake edge ordering monitor (R3, R4, R5)
  always @(link_req or link_ack) begin
    if (mon_on) begin
      if (link_req !== prev_req) begin
        check(link_req ? (link_ack == 1'b0) : (link_ack == 1'b1), "R3 req edge order",
              int'(link_ack), link_req ? 0 : 1);
      end
      if (link_ack !== prev_ack) begin
        if (link_ack) check(link_req == 1'b1, "R4 ack rise order", int'(link_req), 1);
        else          check(link_req == 1'b0, "R5 ack fall order", int'(link_req), 0);
      end
    end
    prev_req = link_req;
    prev_ack = link_ack;
  end

  task automatic verify_word(input int a, input string req);
    rd_addr = AW'(a);
    #1;
    check(rd_data == exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit intrude);
    int base, wait_n, wide;
    @(negedge m_clk);
    while (busy) @(negedge m_clk);
    base = done_cnt;
    wr_addr = a; wr_data = d; start = 1'b1;
    @(negedge m_clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    // Scramble user inputs right after capture (R2)
    wr_addr = ~a; wr_data = ~d;
    if (intrude) begin
      @(negedge m_clk);
      wr_addr = a ^ AW'(1); wr_data = ~d; start = 1'b1;  // R7: ignored while busy
      @(negedge m_clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 1000) begin @(negedge m_clk); wait_n++; end
    check(done == 1'b1, "R6 done seen", int'(done), 1);
    check(link_ack == 1'b0 && link_req == 1'b0, "R6 link idle at done",
          int'({link_req, link_ack}), 0);
    exp_mem[a] = d;
    verify_word(int'(a), "R6 word present at done");
    @(negedge m_clk);
    wide = int'(done);
    check(wide == 0, "R6 done width one cycle", wide, 0);
    repeat (30) @(negedge m_clk);
    check(done_cnt == base + 1, "R7 one done per transfer", done_cnt - base, 1);
    check(busy == 1'b0, "R7 idle after transfer", int'(busy), 0);
    if (intrude) verify_word(int'(a ^ AW'(1)), "R7 intruding start wrote nothing");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    #1;
    check(busy == 1'b0 && done == 1'b0 && link_req == 1'b0 && link_ack == 1'b0,
          "R1 outputs in reset", int'({busy, done, link_req, link_ack}), 0);
    repeat (3) @(negedge m_clk);
    m_rst_n = 1'b1; s_rst_n = 1'b1;
    repeat (6) @(negedge m_clk);
    mon_on = 1'b1;
    check(busy == 1'b0 && done == 1'b0 && link_req == 1'b0 && link_ack == 1'b0,
          "R1 outputs after reset", int'({busy, done, link_req, link_ack}), 0);
    for (int i = 0; i < DEPTH; i++) verify_word(i, "R1 storage cleared");

    // Directed corners: lowest and highest address, all-ones and zero data
    do_write(AW'(0), DW'(8'hA5), 1'b0);
    do_write(AW'(DEPTH-1), '1, 1'b0);
    do_write(AW'(DEPTH-1), '0, 1'b0);
    do_write(AW'(4), DW'(8'h3C), 1'b1);
    do_write(AW'(5), DW'(8'h81), 1'b1);

    // Random writes across unrelated clock phases (R9)
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] ra;
      logic [DW-1:0] rdv;
      ra  = AW'($urandom_range(0, DEPTH-1));
      rdv = DW'($urandom()) ^ mix(n);
      do_write(ra, rdv, ($urandom_range(0, 3) == 0));
    end

    // Full storage sweep: untouched words keep their value (R8)
    for (int i = 0; i < DEPTH; i++) verify_word(i, "R8 read-back sweep");
    check(done_cnt == 65, "R9 all transfers completed", done_cnt, 65);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule